// File: doc/BRIEF.md
# Load/Store Port Requester

This block is the requesting side of a single load/store port. A compute unit hands it one command at a time over a valid/ready interface: a load or store flag, an address, a byte length and, for stores, the write data. The block then runs the port handshake. It raises one operation select line and drives a held address with its valid flag. It waits for the port to accept or reject the address. It then either pulses the store data or captures the returned load data. Finally it reports the result as a one-cycle response that carries an error flag and the loaded data.

Only one transaction is in flight at a time. The command interface is ready only while the controller is idle and the port reports that it is not busy. An abort input returns the controller to idle from any state and produces no response. The controller has five states. IDLE accepts a command (IDLE to ADDR). ADDR holds the address phase; from there an address exception goes to RESP, an address acknowledge on a store goes to STORE, and an address acknowledge on a load goes to LOAD. STORE pulses the write strobe and always moves to RESP. LOAD waits for read-data valid and then moves to RESP. RESP presents the response for one cycle and returns to IDLE. Abort takes any state to IDLE.

Top module: `lsport_master`

## Requirements
- R1: After reset the controller is idle: `cmd_ready` equals the inverse of `port_busy`, and `port_load`, `port_store`, `port_addr_vld`, `port_wstrobe` and `rsp_valid` are all low.
- R2: `cmd_ready` is high only in IDLE while `port_busy` and `abort` are low. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high.
- R3: From the cycle after acceptance until the response cycle, exactly one select line is high: `port_store` when `cmd_store` was 1, otherwise `port_load`. During the same span `port_addr`, `port_len` and `port_addr_vld`=1 hold the accepted values unchanged.
- R4: An address exception seen in ADDR gives a response on the next cycle with `rsp_error`=1. No write strobe follows, and the select and address-valid lines are low in that response cycle.
- R5: For a store, `port_wstrobe` rises only in the cycle after the address acknowledge, stays high for exactly one cycle, and carries the accepted store data on `port_wdata`.
- R6: The cycle after the store strobe is the response cycle: `rsp_valid`=1, `rsp_error`=0, and `port_store` and `port_addr_vld` are low.
- R7: For a load, the controller waits any number of cycles after the acknowledge. On the cycle `port_rdata_vld` is high it captures `port_rdata`, and on the next cycle it responds with `rsp_valid`=1, `rsp_error`=0 and `rsp_rdata` equal to the captured word.
- R8: The value on `port_rdata` has no effect while `port_rdata_vld` is low.
- R9: `abort` takes the controller to IDLE on the next cycle from ADDR or LOAD. No response is produced, and the select and address-valid lines are low.
- R10: While `port_busy` is high, a pending `cmd_valid` is not accepted and no select line is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort | input | 1 | Return to idle, dropping the transaction |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | ADDR_W | Transaction address |
| cmd_len | input | LEN_W | Byte length |
| cmd_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Transaction ended by an address exception |
| rsp_rdata | output | DATA_W | Captured load data |
| port_busy | input | 1 | Port has a transaction in progress |
| port_load | output | 1 | Load select |
| port_store | output | 1 | Store select |
| port_len | output | LEN_W | Byte length to the port |
| port_addr | output | ADDR_W | Held address |
| port_addr_vld | output | 1 | Address valid |
| port_addr_ack | input | 1 | One-cycle address acknowledge |
| port_addr_exc | input | 1 | One-cycle address exception |
| port_wdata | output | DATA_W | Store data |
| port_wstrobe | output | 1 | One-cycle store data valid |
| port_rdata | input | DATA_W | Load data |
| port_rdata_vld | input | 1 | One-cycle load data valid |

## Verification
Stores and loads are run with address acknowledges that arrive immediately and ones that arrive after several waiting cycles. This separates a controller that really holds the address phase from one that advances on a timer. Loads are given returned data late, with changing garbage on the data lines before the valid strobe. This shows whether capture is tied to the strobe alone. An address exception, aborts in two different states, and a command held against a busy port check that the error path, the abort path and the admission gate each end the transaction without a stray strobe or response.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_STORE = 3'd2,
        S_LOAD  = 3'd3,
        S_RESP  = 3'd4
    } lsm_state_e;
endpackage

// File: rtl/lsm_cmd_reg.sv
module lsm_cmd_reg #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] port_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    // command fields are held for the whole transaction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            len_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= cmd_addr;
            len_q   <= cmd_len;
            wdata_q <= cmd_wdata;
        end
    end

    // load data taken only on its valid strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= port_rdata;
    end
endmodule

// File: rtl/lsm_fsm.sv
module lsm_fsm
    import lsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic cmd_valid,
    input  logic cmd_store,
    input  logic port_busy,
    input  logic port_addr_ack,
    input  logic port_addr_exc,
    input  logic port_rdata_vld,
    output logic accept,
    output logic capture,
    output logic cmd_ready,
    output logic port_load,
    output logic port_store,
    output logic port_addr_vld,
    output logic port_wstrobe,
    output logic rsp_valid,
    output logic rsp_error
);
    lsm_state_e state_q, state_d;
    logic       store_q;
    logic       err_q;

    assign accept  = (state_q == S_IDLE) && cmd_valid && !port_busy && !abort;
    assign capture = (state_q == S_LOAD) && port_rdata_vld && !abort;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_ADDR;
            S_ADDR: begin
                if (port_addr_exc)      state_d = S_RESP;
                else if (port_addr_ack) state_d = store_q ? S_STORE : S_LOAD;
            end
            S_STORE: state_d = S_RESP;
            S_LOAD:  if (port_rdata_vld) state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (abort) state_d = S_IDLE;
    end

    // state register with operation type and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            store_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                store_q <= cmd_store;
                err_q   <= 1'b0;
            end else if (state_q == S_ADDR && port_addr_exc) begin
                err_q   <= 1'b1;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        cmd_ready     = 1'b0;
        port_load     = 1'b0;
        port_store    = 1'b0;
        port_addr_vld = 1'b0;
        port_wstrobe  = 1'b0;
        rsp_valid     = 1'b0;
        rsp_error     = 1'b0;
        unique case (state_q)
            S_IDLE:  cmd_ready = !port_busy && !abort;
            S_ADDR, S_LOAD: begin
                port_load     = !store_q;
                port_store    = store_q;
                port_addr_vld = 1'b1;
            end
            S_STORE: begin
                port_store    = 1'b1;
                port_addr_vld = 1'b1;
                port_wstrobe  = 1'b1;
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                rsp_error = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsport_master.sv
module lsport_master #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_store,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              port_busy,
    output logic              port_load,
    output logic              port_store,
    output logic [LEN_W-1:0]  port_len,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_addr_vld,
    input  logic              port_addr_ack,
    input  logic              port_addr_exc,
    output logic [DATA_W-1:0] port_wdata,
    output logic              port_wstrobe,
    input  logic [DATA_W-1:0] port_rdata,
    input  logic              port_rdata_vld
);
    logic accept;
    logic capture;

    lsm_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .abort          (abort),
        .cmd_valid      (cmd_valid),
        .cmd_store      (cmd_store),
        .port_busy      (port_busy),
        .port_addr_ack  (port_addr_ack),
        .port_addr_exc  (port_addr_exc),
        .port_rdata_vld (port_rdata_vld),
        .accept         (accept),
        .capture        (capture),
        .cmd_ready      (cmd_ready),
        .port_load      (port_load),
        .port_store     (port_store),
        .port_addr_vld  (port_addr_vld),
        .port_wstrobe   (port_wstrobe),
        .rsp_valid      (rsp_valid),
        .rsp_error      (rsp_error)
    );

    lsm_cmd_reg #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .cmd_addr   (cmd_addr),
        .cmd_len    (cmd_len),
        .cmd_wdata  (cmd_wdata),
        .port_rdata (port_rdata),
        .addr_q     (port_addr),
        .len_q      (port_len),
        .wdata_q    (port_wdata),
        .rdata_q    (rsp_rdata)
    );
endmodule

// File: rtl/lsport_master_chk.sv
module lsport_master_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              rsp_error,
    input logic              port_busy,
    input logic              port_load,
    input logic              port_store,
    input logic [ADDR_W-1:0] port_addr,
    input logic              port_addr_vld,
    input logic              port_addr_ack,
    input logic              port_addr_exc,
    input logic              port_wstrobe
);
    assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_load && port_store));

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr_vld && $past(port_addr_vld)) |-> ($stable(port_addr) && $stable(port_store)));

    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!port_busy && !port_addr_vld && !abort));

    assert_exc_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr_vld && !port_wstrobe && port_addr_exc && !abort) |=> (rsp_valid && rsp_error && !port_wstrobe));

    assert_strobe_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        port_wstrobe |-> ($past(port_addr_ack) && $past(port_store)));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        port_wstrobe |=> !port_wstrobe);

    assert_rsp_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!port_load && !port_store && !port_addr_vld));

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!port_addr_vld && !rsp_valid));
endmodule

bind lsport_master lsport_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort         (abort),
    .cmd_ready     (cmd_ready),
    .rsp_valid     (rsp_valid),
    .rsp_error     (rsp_error),
    .port_busy     (port_busy),
    .port_load     (port_load),
    .port_store    (port_store),
    .port_addr     (port_addr),
    .port_addr_vld (port_addr_vld),
    .port_addr_ack (port_addr_ack),
    .port_addr_exc (port_addr_exc),
    .port_wstrobe  (port_wstrobe)
);

// File: tb/test_lsport_master.sv
module test_lsport_master;
    localparam int DW = 64;
    localparam int AW = 48;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          abort = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_store = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid, rsp_error;
    logic [DW-1:0] rsp_rdata;
    logic          port_busy = 1'b0;
    logic          port_load, port_store, port_addr_vld, port_wstrobe;
    logic [LW-1:0] port_len;
    logic [AW-1:0] port_addr;
    logic          port_addr_ack = 1'b0;
    logic          port_addr_exc = 1'b0;
    logic [DW-1:0] port_wdata;
    logic [DW-1:0] port_rdata = '0;
    logic          port_rdata_vld = 1'b0;

    int checks = 0;
    int errors = 0;
    bit         exp_err[$];
    logic [DW-1:0] exp_data[$];

    always #5 clk = ~clk;

    lsport_master #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) i_lsport_master (
        .clk(clk), .rst_n(rst_n), .abort(abort),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .port_busy(port_busy), .port_load(port_load), .port_store(port_store),
        .port_len(port_len), .port_addr(port_addr), .port_addr_vld(port_addr_vld),
        .port_addr_ack(port_addr_ack), .port_addr_exc(port_addr_exc),
        .port_wdata(port_wdata), .port_wstrobe(port_wstrobe),
        .port_rdata(port_rdata), .port_rdata_vld(port_rdata_vld)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a response appears
    always @(negedge clk) begin
        #2;
        if (rst_n && rsp_valid) begin
            if (exp_err.size() == 0) begin
                chk(1'b0, "R9", "unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                automatic bit e = exp_err.pop_front();
                automatic logic [DW-1:0] d = exp_data.pop_front();
                chk(rsp_error == e, e ? "R4" : "R6", "rsp_error", 64'(rsp_error), 64'(e));
                if (!e) chk(rsp_rdata == d, "R7", "rsp_rdata", rsp_rdata, d);
            end
        end
    end

    // offer a command and check the address phase that follows
    task automatic start_cmd(input bit st, input logic [AW-1:0] a,
                             input logic [LW-1:0] l, input logic [DW-1:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = st; cmd_addr = a; cmd_len = l; cmd_wdata = wd;
        #1 chk(cmd_ready == 1'b1, "R2", "cmd_ready when idle", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_addr = ~a; cmd_wdata = ~wd;
        #1;
        chk(port_store == st && port_load == !st, "R3", "select lines",
            64'({port_load, port_store}), 64'({!st, st}));
        chk(port_addr_vld && port_addr == a && port_len == l, "R3", "address phase",
            64'(port_addr), 64'(a));
    endtask

    task automatic hold_addr(input int n, input logic [AW-1:0] a);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            chk(port_addr_vld && port_addr == a && !port_wstrobe, "R3", "address held",
                64'(port_addr), 64'(a));
        end
    endtask

    task automatic ack_addr();
        @(negedge clk); port_addr_ack = 1'b1;
        #1 chk(port_wstrobe == 1'b0, "R5", "no strobe with ack", 64'(port_wstrobe), 64'd0);
        @(negedge clk); port_addr_ack = 1'b0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [LW-1:0] l,
                            input logic [DW-1:0] wd, input int wait_n);
        start_cmd(1'b1, a, l, wd);
        hold_addr(wait_n, a);
        ack_addr();
        #1;
        chk(port_wstrobe == 1'b1, "R5", "store strobe", 64'(port_wstrobe), 64'd1);
        chk(port_wdata == wd, "R5", "store data", port_wdata, wd);
        exp_err.push_back(1'b0); exp_data.push_back('0);
        @(negedge clk); #1;
        chk(!port_wstrobe && !port_store && !port_addr_vld, "R6", "released after strobe",
            64'({port_wstrobe, port_store, port_addr_vld}), 64'd0);
        @(negedge clk);
    endtask

    task automatic finish_load(input logic [DW-1:0] rd, input int data_n);
        for (int i = 0; i < data_n; i++) begin
            port_rdata = {rd[DW/2-1:0], rd[DW-1:DW/2]} ^ DW'(i + 1);
            #1 chk(port_load && port_addr_vld, "R7", "load waits for data",
                   64'(port_load), 64'd1);
            @(negedge clk);
        end
        port_rdata = rd; port_rdata_vld = 1'b1;
        exp_err.push_back(1'b0); exp_data.push_back(rd);
        @(negedge clk);
        port_rdata_vld = 1'b0; port_rdata = ~rd;
        #1 chk(!port_load && !port_addr_vld, "R7", "released after capture",
               64'({port_load, port_addr_vld}), 64'd0);
        @(negedge clk);
        #1 chk(rsp_rdata == rd, "R8", "data unaffected after capture", rsp_rdata, rd);
    endtask

    task automatic do_load(input logic [AW-1:0] a, input logic [LW-1:0] l,
                           input logic [DW-1:0] rd, input int wait_n, input int data_n);
        start_cmd(1'b0, a, l, '0);
        hold_addr(wait_n, a);
        ack_addr();
        finish_load(rd, data_n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(cmd_ready && !port_load && !port_store && !port_addr_vld && !port_wstrobe && !rsp_valid,
            "R1", "idle after reset", 64'({cmd_ready, port_load, port_store, port_addr_vld}), 64'h8);
        port_busy = 1'b1; #1;
        chk(cmd_ready == 1'b0, "R1", "ready follows busy", 64'(cmd_ready), 64'd0);
        port_busy = 1'b0;

        do_store(48'h0000_0000_0002, 4'd2, 64'h0000_0000_0000_beef, 0);
        do_store(48'h1234_5678_9ab8, 4'd8, 64'hdead_beef_0bad_f00d, 3);
        do_load(48'h0000_0000_0004, 4'd2, 64'h0000_0000_0000_f00f, 0, 0);
        do_load(48'h0000_0000_0010, 4'd4, 64'hcafe_babe_1357_2468, 2, 4);

        // R4: address exception ends the transaction with error
        start_cmd(1'b1, 48'h0fff_0000_0040, 4'd1, 64'h55);
        hold_addr(1, 48'h0fff_0000_0040);
        @(negedge clk); port_addr_exc = 1'b1;
        exp_err.push_back(1'b1); exp_data.push_back('0);
        @(negedge clk); port_addr_exc = 1'b0;
        #1 chk(!port_wstrobe && !port_store && !port_addr_vld, "R4", "no data phase after exception",
               64'({port_wstrobe, port_store, port_addr_vld}), 64'd0);
        @(negedge clk); @(negedge clk);
        #1 chk(!port_wstrobe, "R4", "no late strobe", 64'(port_wstrobe), 64'd0);

        // R9: abort in address phase
        start_cmd(1'b1, 48'h77, 4'd8, 64'h99);
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        #1 chk(!port_store && !port_addr_vld && cmd_ready, "R9", "abort from address phase",
               64'({port_store, port_addr_vld, cmd_ready}), 64'd1);

        // R9: abort while waiting for load data
        start_cmd(1'b0, 48'h88, 4'd4, '0);
        ack_addr();
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        #1 chk(!port_load && !port_addr_vld && cmd_ready, "R9", "abort from load wait",
               64'({port_load, port_addr_vld, cmd_ready}), 64'd1);
        @(negedge clk);

        // R10: a command held against a busy port is not taken
        port_busy = 1'b1; cmd_valid = 1'b1; cmd_store = 1'b0;
        cmd_addr = 48'h3c0; cmd_len = 4'd8;
        for (int i = 0; i < 3; i++) begin
            #1 chk(!cmd_ready, "R10", "not ready while busy", 64'(cmd_ready), 64'd0);
            @(negedge clk);
            #1 chk(!port_load && !port_store, "R10", "no select while busy",
                   64'({port_load, port_store}), 64'd0);
        end
        port_busy = 1'b0;
        #1 chk(cmd_ready, "R2", "ready once busy falls", 64'(cmd_ready), 64'd1);
        @(negedge clk); cmd_valid = 1'b0;
        #1 chk(port_load && port_addr == 48'h3c0, "R3", "load after busy", 64'(port_addr), 64'h3c0);
        ack_addr();
        finish_load(64'h0123_4567_89ab_cdef, 1);

        repeat (3) @(negedge clk);
        chk(exp_err.size() == 0, "R6", "all responses seen", 64'(exp_err.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule